// File: doc/BRIEF.md
# Timed Page Write Buffer

This block collects the bytes of one write burst aimed at a 16-byte page of a 2048 x 8 storage array, then puts the whole page into the array in a single timed write cycle. A protocol layer opens a burst by loading an 11-bit start address. It sends data bytes one strobe at a time and closes the burst with a commit strobe. The upper seven address bits pick the page. The lower four bits give the starting slot, which steps and wraps inside the page.

When the commit is taken, the block steps through all sixteen addresses of the page, from offset 0 to offset 15. A buffered byte goes to its address. Each address that received no byte is written again with the value it already holds. The busy flag stays high for a fixed number of clock cycles, and load, byte and commit strobes are ignored for that whole time. A write-protect input is sampled at the commit. When it is high, the cycle runs but no array location is written. A separate read port reads the array at any time.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, busy_o and arr_we_o are low.
- R2: A load strobe takes the page number from load_addr_i[10:4] and the starting slot from load_addr_i[3:0]. Each later byte strobe stores its byte at the next consecutive address of that page.
- R3: The slot pointer increments in its low 4 bits only. A byte that follows slot 15 goes to slot 0 of the same page, and the page number never changes.
- R4: When more than 16 bytes arrive before a commit, a later byte replaces the earlier byte held for the same slot. After the commit each slot holds the last byte sent to it.
- R5: A taken commit writes all 16 addresses of the page on arr_we_o, once each, in rising address order. Slots that received no byte keep their previous contents.
- R6: Buffered bytes do not reach the array until a commit strobe arrives.
- R7: busy_o rises in the cycle after the commit strobe is sampled and stays high for exactly WRITE_CYCLES cycles.
- R8: While busy_o is high, load, byte and commit strobes are ignored. The buffer is empty once the cycle ends.
- R9: wp_i is sampled with the commit. When it is high, the write cycle and busy_o run as usual, but arr_we_o stays low and no array contents change.
- R10: A commit strobe with no byte buffered starts no cycle, and busy_o stays low.
- R11: rd_data_o shows the array byte at rd_addr_i in the same cycle, including while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a burst at load_addr_i |
| load_addr_i | input | 11 | Burst start address |
| byte_wr_i | input | 1 | Store byte_i at the current slot |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop strobe that starts the write cycle |
| wp_i | input | 1 | Write protect, sampled at commit |
| rd_addr_i | input | 11 | Read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |
| busy_o | output | 1 | Write cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 11 | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
Several burst shapes are driven, and each one separates a different fault:
- Full-page fills check the basic placement of bytes.
- A short burst in mid-page shows whether untouched slots are refreshed or lost.
- A burst that runs past slot 15 shows whether the pointer wraps inside the page or carries into the page number.
- An 18-byte burst shows whether the last byte wins its slot.

Protected commits, empty commits and strobes sent while busy each test a path that must leave the array alone. For every taken commit, the bench measures the length of busy and counts the array writes.

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int ADDR_W       = 11,
  parameter int OFS_W        = 4,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              byte_wr_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o
);
  localparam int SLOTS  = 1 << OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pbuf [SLOTS];
  logic [SLOTS-1:0]  valid;
  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic [CNT_W-1:0]  cnt;
  logic              busy, wp_q;

  wire              walking = busy && (cnt < CNT_W'(SLOTS));
  wire [OFS_W-1:0]  wofs    = cnt[OFS_W-1:0];
  wire              take_b  = !busy && !load_i && byte_wr_i;

  assign arr_addr_o  = {page, wofs};
  assign arr_we_o    = walking && !wp_q;
  assign arr_wdata_o = valid[wofs] ? pbuf[wofs] : mem[arr_addr_o];
  assign rd_data_o   = mem[rd_addr_i];
  assign busy_o      = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      valid <= '0;
      page  <= '0;
      ofs   <= '0;
      wp_q  <= 1'b0;
    end else if (busy) begin
      if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
        busy  <= 1'b0;
        cnt   <= '0;
        valid <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (load_i) begin
      page  <= load_addr_i[ADDR_W-1:OFS_W];
      ofs   <= load_addr_i[OFS_W-1:0];
      valid <= '0;
    end else if (byte_wr_i) begin
      valid[ofs] <= 1'b1;
      ofs        <= ofs + 1'b1;
    end else if (commit_i && |valid) begin
      busy <= 1'b1;
      wp_q <= wp_i;
    end
  end

  always_ff @(posedge clk)
    if (take_b) pbuf[ofs] <= byte_i;

  always_ff @(posedge clk)
    if (arr_we_o) mem[arr_addr_o] <= arr_wdata_o;

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i));

  // R5
  walk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o == $past(arr_addr_o) + 1'b1);

  // R10
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !load_i && !byte_wr_i && commit_i && valid == '0 |=> !busy_o);

  // R8
  buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(valid) && $stable(page));
endmodule

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 24;

  logic        clk = 0, rst_n = 0;
  logic        load_i = 0, byte_wr_i = 0, commit_i = 0, wp_i = 0;
  logic [10:0] load_addr_i = '0, rd_addr_i = '0;
  logic [7:0]  byte_i = '0;
  logic [7:0]  rd_data_o, arr_wdata_o;
  logic [10:0] arr_addr_o;
  logic        busy_o, arr_we_o;

  eeprom_page_commit #(.WRITE_CYCLES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
    .byte_wr_i(byte_wr_i), .byte_i(byte_i), .commit_i(commit_i), .wp_i(wp_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, we_cnt = 0;
  logic [7:0]  model [2048];
  logic [6:0]  ppage = '0;
  logic [3:0]  pofs = '0;
  logic [7:0]  pdata [16];
  logic [15:0] pvalid = '0;
  bit          exp_cycle;
  int          exp_we;

  logic [7:0]  exp_q [$];
  logic [10:0] addr_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (arr_we_o) we_cnt++;

  always @(negedge clk)
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [10:0] a;
      string t;
      e = exp_q.pop_front(); a = addr_q.pop_front(); t = tag_q.pop_front();
      chk(rd_data_o === e && rd_addr_i === a, t, rd_data_o, e);
    end

  task automatic drv_load(input logic [10:0] a, input bit take);
    load_i = 1; load_addr_i = a;
    if (take) begin ppage = a[10:4]; pofs = a[3:0]; pvalid = '0; end
    @(posedge clk); #1; load_i = 0;
  endtask

  task automatic drv_bytes(input int n, input logic [7:0] base, input bit take);
    for (int i = 0; i < n; i++) begin
      byte_wr_i = 1; byte_i = base + 8'(i);
      if (take) begin pdata[pofs] = byte_i; pvalid[pofs] = 1'b1; pofs = pofs + 1'b1; end
      @(posedge clk); #1;
    end
    byte_wr_i = 0;
  endtask

  task automatic drv_commit(input bit wp, input bit take);
    commit_i = 1; wp_i = wp;
    if (take) begin
      exp_cycle = (pvalid != 0);
      exp_we = (exp_cycle && !wp) ? 16 : 0;
      if (exp_cycle && !wp)
        for (int i = 0; i < 16; i++)
          if (pvalid[i]) model[{ppage, 4'(i)}] = pdata[i];
      pvalid = '0;
      we_cnt = 0;
    end
    @(posedge clk); #1; commit_i = 0; wp_i = 0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    for (int k = 0; k < W + 8; k++) begin
      @(negedge clk);
      if (busy_o) n++; else break;
    end
    chk(n == (exp_cycle ? W : 0), tag, n, exp_cycle ? W : 0);
    chk(we_cnt == exp_we, tag, we_cnt, exp_we);
    @(posedge clk); #1;
  endtask

  task automatic read_page(input logic [6:0] pg, input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr_i = {pg, 4'(i)};
      exp_q.push_back(model[rd_addr_i]); addr_q.push_back(rd_addr_i); tag_q.push_back(tag);
      @(posedge clk); #1;
    end
  endtask

  task automatic burst(input logic [10:0] a, input int n, input logic [7:0] base,
                       input bit wp, input string tag);
    drv_load(a, 1); drv_bytes(n, base, 1); drv_commit(wp, 1); wait_done(tag);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy", busy_o, 0);
    chk(arr_we_o === 1'b0, "R1 we", arr_we_o, 0);
    @(posedge clk); #1; rst_n = 1;

    burst(11'h050, 16, 8'h10, 0, "R7 fill p5");
    read_page(7'h05, "R2 p5");
    burst(11'h030, 16, 8'hA0, 0, "R7 fill p3");
    read_page(7'h03, "R2 p3");
    burst(11'h7F0, 16, 8'h40, 0, "R7 fill p127");

    drv_load(11'h05C, 1); drv_bytes(3, 8'hC0, 1);
    read_page(7'h05, "R6 before commit");
    drv_commit(0, 1); wait_done("R5 partial");
    read_page(7'h05, "R5 refresh");

    burst(11'h05E, 4, 8'hD0, 0, "R3 wrap cycle");
    read_page(7'h05, "R3 wrap p5");
    burst(11'h7FF, 2, 8'hE0, 0, "R3 top cycle");
    read_page(7'h7F, "R3 wrap p127");

    burst(11'h033, 18, 8'h60, 0, "R4 overflow cycle");
    read_page(7'h03, "R4 overwrite");

    burst(11'h050, 5, 8'h99, 1, "R9 protect cycle");
    read_page(7'h05, "R9 unchanged");

    drv_load(11'h030, 1); drv_commit(0, 1); wait_done("R10 empty");
    drv_commit(0, 1); wait_done("R10 bare commit");

    drv_load(11'h030, 1); drv_bytes(2, 8'h11, 1); drv_commit(0, 1);
    read_page(7'h7F, "R11 read while busy");
    drv_load(11'h050, 0); drv_bytes(3, 8'h77, 0); drv_commit(0, 0);
    while (busy_o) @(negedge clk);
    @(posedge clk); #1;
    chk(we_cnt == 16, "R5 probe writes", we_cnt, 16);
    drv_commit(0, 1); wait_done("R8 ignored strobes");
    read_page(7'h05, "R8 p5");
    read_page(7'h03, "R8 p3");

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule